// File: doc/BRIEF.md
# Youngest-Definition Operand Finder

This block sits next to a circular buffer of in-flight results. For a source register number it finds the in-flight entry that most recently named that register as its destination. The search covers only the live part of the queue, between the head (oldest) and the tail (next free slot). It walks from the entry just below the tail back toward the head, so the nearest earlier definition wins over older ones for the same register. The walk is a serial chain with one stage per buffer slot, so its depth grows linearly with the buffer size.

The buffer contents are inputs: a destination register number, a data word and a done bit for every slot, plus head and tail pointers. Each pointer carries one extra wrap bit, so an empty queue and a full queue can be told apart. The register file value is read elsewhere and presented on its own input. When nothing in flight defines the register, the block forwards that value, marked ready. A request is answered one clock later from a registered result.

Top module: `opl_lookup`

## Requirements
- R1: `rsp_valid` equals `req_valid` delayed by exactly one clock, and the response describes the inputs seen in the cycle of the request.
- R2: `rsp_hit` is 1 only if a live slot's destination equals `req_reg`, and `rsp_idx` then names such a slot.
- R3: When several live slots hold the requested register, the slot nearest below the tail is reported, which is the youngest one.
- R4: The live slots run from index `head_ptr[IW-1:0]` up to `tail_ptr[IW-1:0]-1`, wrapping modulo DEPTH. The count of live slots is `tail_ptr - head_ptr` taken modulo 2*DEPTH, so equal indices with different wrap bits (bit IW) mean a full queue.
- R5: A slot outside the live window never produces a hit, even when its destination matches.
- R6: When `head_ptr == tail_ptr`, the queue is empty and the response is always a miss.
- R7: On a miss, `rsp_data` equals the `arf_rdata` of the request cycle, `rsp_ready` is 1 and `rsp_idx` is 0.
- R8: On a hit, `rsp_data` is the data of slot `rsp_idx`, and `rsp_ready` is that slot's done bit (1 means the result is written).
- R9: During reset, and after it until the first request, all outputs are 0.
- R10: In a cycle after `req_valid` is low, `rsp_valid` is 0 and `rsp_hit`, `rsp_idx`, `rsp_data` and `rsp_ready` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request this cycle |
| req_reg | input | REG_W | Source register number to find |
| head_ptr | input | IW+1 | Oldest live slot, with wrap bit |
| tail_ptr | input | IW+1 | Next free slot, with wrap bit |
| ent_dst | input | DEPTH*REG_W | Destination register of each slot, slot i at bits i*REG_W |
| ent_data | input | DEPTH*DATA_W | Result word of each slot, slot i at bits i*DATA_W |
| ent_done | input | DEPTH | Result-written bit of each slot |
| arf_rdata | input | DATA_W | Register file value for `req_reg` |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | An in-flight definition was found |
| rsp_idx | output | IW | Slot holding the found definition |
| rsp_data | output | DATA_W | Operand value |
| rsp_ready | output | 1 | Operand value is final |

## Verification
The bound checker captures each request's inputs. On every cycle it checks that a hit names a live slot whose destination matches, and that it carries that slot's data and done bit. It also checks that a miss forwards the register file word marked ready, that an empty queue never hits, and that idle cycles leave the response unchanged. The checker does not prove that the youngest of several matches wins, or that the window is placed correctly after the pointers wrap. The bench shows these with known buffer contents and pointer pairs that wrap, fill the queue or empty it.

// File: rtl/opl_pkg.sv
package opl_pkg;

    typedef struct packed {
        logic valid;
        logic hit;
        logic ready;
    } rsp_flags_t;

endpackage

// File: rtl/opl_window.sv
module opl_window #(
    parameter int DEPTH = 8,
    parameter int IW    = $clog2(DEPTH)
) (
    input  logic [IW:0]          head_ptr,
    input  logic [IW:0]          tail_ptr,
    output logic [IW:0]          occupancy,
    output logic [DEPTH*IW-1:0]  rank_idx,
    output logic [DEPTH-1:0]     rank_live
);

    // live count; the wrap bit makes full read as DEPTH
    assign occupancy = tail_ptr - head_ptr;

    // rank 0 is the youngest slot, just below the tail
    for (genvar k = 0; k < DEPTH; k++) begin : g_rank
        localparam logic [IW-1:0] STEP = IW'(k + 1);
        localparam logic [IW:0]   RANK = (IW + 1)'(k);
        assign rank_idx[k*IW +: IW] = tail_ptr[IW-1:0] - STEP;
        assign rank_live[k]         = RANK < occupancy;
    end

endmodule

// File: rtl/opl_scan_stage.sv
module opl_scan_stage #(
    parameter int REG_W  = 5,
    parameter int DATA_W = 16,
    parameter int IW     = 3
) (
    input  logic              found_i,
    input  logic [IW-1:0]     idx_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              done_i,
    input  logic              live,
    input  logic [REG_W-1:0]  slot_dst,
    input  logic [DATA_W-1:0] slot_data,
    input  logic              slot_done,
    input  logic [IW-1:0]     slot_idx,
    input  logic [REG_W-1:0]  req_reg,
    output logic              found_o,
    output logic [IW-1:0]     idx_o,
    output logic [DATA_W-1:0] data_o,
    output logic              done_o
);

    logic match;

    always_comb begin
        match = live && (slot_dst == req_reg);
        // an earlier (younger) stage that already hit keeps priority
        if (found_i) begin
            found_o = 1'b1;
            idx_o   = idx_i;
            data_o  = data_i;
            done_o  = done_i;
        end else if (match) begin
            found_o = 1'b1;
            idx_o   = slot_idx;
            data_o  = slot_data;
            done_o  = slot_done;
        end else begin
            found_o = 1'b0;
            idx_o   = '0;
            data_o  = '0;
            done_o  = 1'b0;
        end
    end

endmodule

// File: rtl/opl_lookup.sv
module opl_lookup
    import opl_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int REG_W  = 5,
    parameter int DATA_W = 16,
    parameter int IW     = $clog2(DEPTH)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    input  logic [REG_W-1:0]        req_reg,
    input  logic [IW:0]             head_ptr,
    input  logic [IW:0]             tail_ptr,
    input  logic [DEPTH*REG_W-1:0]  ent_dst,
    input  logic [DEPTH*DATA_W-1:0] ent_data,
    input  logic [DEPTH-1:0]        ent_done,
    input  logic [DATA_W-1:0]       arf_rdata,
    output logic                    rsp_valid,
    output logic                    rsp_hit,
    output logic [IW-1:0]           rsp_idx,
    output logic [DATA_W-1:0]       rsp_data,
    output logic                    rsp_ready
);

    typedef struct packed {
        rsp_flags_t        f;
        logic [IW-1:0]     idx;
        logic [DATA_W-1:0] data;
    } rsp_state_t;

    rsp_state_t st_d, st_q;

    logic [IW:0]         occupancy;
    logic [DEPTH*IW-1:0] rank_idx;
    logic [DEPTH-1:0]    rank_live;

    opl_window #(.DEPTH(DEPTH), .IW(IW)) u_win (
        .head_ptr  (head_ptr),
        .tail_ptr  (tail_ptr),
        .occupancy (occupancy),
        .rank_idx  (rank_idx),
        .rank_live (rank_live)
    );

    // daisy chain, youngest rank first
    logic [DEPTH:0]    found_c;
    logic [IW-1:0]     idx_c  [DEPTH+1];
    logic [DATA_W-1:0] data_c [DEPTH+1];
    logic [DEPTH:0]    done_c;

    assign found_c[0] = 1'b0;
    assign idx_c[0]   = '0;
    assign data_c[0]  = '0;
    assign done_c[0]  = 1'b0;

    for (genvar k = 0; k < DEPTH; k++) begin : g_chain
        logic [IW-1:0]     pidx;
        logic [REG_W-1:0]  sdst;
        logic [DATA_W-1:0] sdata;
        logic              sdone;

        assign pidx  = rank_idx[k*IW +: IW];
        assign sdst  = ent_dst[pidx*REG_W +: REG_W];
        assign sdata = ent_data[pidx*DATA_W +: DATA_W];
        assign sdone = ent_done[pidx];

        opl_scan_stage #(.REG_W(REG_W), .DATA_W(DATA_W), .IW(IW)) u_stage (
            .found_i   (found_c[k]),
            .idx_i     (idx_c[k]),
            .data_i    (data_c[k]),
            .done_i    (done_c[k]),
            .live      (rank_live[k]),
            .slot_dst  (sdst),
            .slot_data (sdata),
            .slot_done (sdone),
            .slot_idx  (pidx),
            .req_reg   (req_reg),
            .found_o   (found_c[k+1]),
            .idx_o     (idx_c[k+1]),
            .data_o    (data_c[k+1]),
            .done_o    (done_c[k+1])
        );
    end

    always_comb begin
        st_d         = st_q;
        st_d.f.valid = req_valid;
        if (req_valid) begin
            if (found_c[DEPTH] && (occupancy != '0)) begin
                st_d.f.hit   = 1'b1;
                st_d.f.ready = done_c[DEPTH];
                st_d.idx     = idx_c[DEPTH];
                st_d.data    = data_c[DEPTH];
            end else begin
                st_d.f.hit   = 1'b0;
                st_d.f.ready = 1'b1;
                st_d.idx     = '0;
                st_d.data    = arf_rdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rsp_valid = st_q.f.valid;
    assign rsp_hit   = st_q.f.hit;
    assign rsp_ready = st_q.f.ready;
    assign rsp_idx   = st_q.idx;
    assign rsp_data  = st_q.data;

endmodule

// File: rtl/opl_lookup_chk.sv
module opl_lookup_chk #(
    parameter int DEPTH  = 8,
    parameter int REG_W  = 5,
    parameter int DATA_W = 16,
    parameter int IW     = $clog2(DEPTH)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    input  logic [REG_W-1:0]        req_reg,
    input  logic [IW:0]             head_ptr,
    input  logic [IW:0]             tail_ptr,
    input  logic [DEPTH*REG_W-1:0]  ent_dst,
    input  logic [DEPTH*DATA_W-1:0] ent_data,
    input  logic [DEPTH-1:0]        ent_done,
    input  logic [DATA_W-1:0]       arf_rdata,
    input  logic                    rsp_valid,
    input  logic                    rsp_hit,
    input  logic [IW-1:0]           rsp_idx,
    input  logic [DATA_W-1:0]       rsp_data,
    input  logic                    rsp_ready
);

    localparam logic [IW:0] FULL = (IW + 1)'(DEPTH);

    logic [REG_W-1:0]        s_req;
    logic [IW:0]             s_head, s_tail;
    logic [DEPTH*REG_W-1:0]  s_dst;
    logic [DEPTH*DATA_W-1:0] s_data;
    logic [DEPTH-1:0]        s_done;
    logic [DATA_W-1:0]       s_arf;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_req <= '0; s_head <= '0; s_tail <= '0;
            s_dst <= '0; s_data <= '0; s_done <= '0; s_arf <= '0;
        end else if (req_valid) begin
            s_req <= req_reg; s_head <= head_ptr; s_tail <= tail_ptr;
            s_dst <= ent_dst; s_data <= ent_data; s_done <= ent_done;
            s_arf <= arf_rdata;
        end
    end

    logic [IW:0]   s_count;
    logic [IW-1:0] hit_ofs;
    assign s_count = s_tail - s_head;
    assign hit_ofs = rsp_idx - s_head[IW-1:0];

    // R1
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_valid && $stable(rsp_hit) && $stable(rsp_data)
                        && $stable(rsp_idx) && $stable(rsp_ready)));
    // R2
    hit_dst_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_hit) |-> (s_dst[rsp_idx*REG_W +: REG_W] == s_req));
    // R5
    hit_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_hit) |-> ({1'b0, hit_ofs} < s_count));
    // R4
    ptr_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> ((tail_ptr - head_ptr) <= FULL));
    // R6
    empty_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && head_ptr == tail_ptr) |=> !rsp_hit);
    // R7
    miss_arf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> (rsp_data == s_arf && rsp_ready && rsp_idx == '0));
    // R8
    hit_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_hit) |->
        (rsp_data == s_data[rsp_idx*DATA_W +: DATA_W] && rsp_ready == s_done[rsp_idx]));

endmodule

bind opl_lookup opl_lookup_chk #(
    .DEPTH(DEPTH), .REG_W(REG_W), .DATA_W(DATA_W), .IW(IW)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_reg(req_reg),
    .head_ptr(head_ptr), .tail_ptr(tail_ptr), .ent_dst(ent_dst),
    .ent_data(ent_data), .ent_done(ent_done), .arf_rdata(arf_rdata),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_idx(rsp_idx),
    .rsp_data(rsp_data), .rsp_ready(rsp_ready)
);

// File: tb/sim_opl_lookup.sv
module sim_opl_lookup;

    localparam int DEPTH  = 8;
    localparam int REG_W  = 5;
    localparam int DATA_W = 16;
    localparam int IW     = 3;
    localparam int NVEC   = 13;

    logic                    clk = 1'b0;
    logic                    rst_n;
    logic                    req_valid;
    logic [REG_W-1:0]        req_reg;
    logic [IW:0]             head_ptr, tail_ptr;
    logic [DEPTH*REG_W-1:0]  ent_dst;
    logic [DEPTH*DATA_W-1:0] ent_data;
    logic [DEPTH-1:0]        ent_done;
    logic [DATA_W-1:0]       arf_rdata;
    logic                    rsp_valid, rsp_hit, rsp_ready;
    logic [IW-1:0]           rsp_idx;
    logic [DATA_W-1:0]       rsp_data;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    opl_lookup #(.DEPTH(DEPTH), .REG_W(REG_W), .DATA_W(DATA_W)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_reg(req_reg),
        .head_ptr(head_ptr), .tail_ptr(tail_ptr), .ent_dst(ent_dst),
        .ent_data(ent_data), .ent_done(ent_done), .arf_rdata(arf_rdata),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_idx(rsp_idx),
        .rsp_data(rsp_data), .rsp_ready(rsp_ready)
    );

    // slot destinations: 0:3 1:7 2:3 3:9 4:7 5:3 6:12 7:7
    localparam logic [REG_W-1:0] DSTS [DEPTH] = '{5'd3, 5'd7, 5'd3, 5'd9, 5'd7, 5'd3, 5'd12, 5'd7};

    // {head, tail, reg, exp_hit, exp_idx}
    localparam logic [16:0] VECS [NVEC] = '{
        {4'd0,  4'd8,  5'd3,  1'b1, 3'd5},  // R3 full, three matches
        {4'd0,  4'd8,  5'd7,  1'b1, 3'd7},  // R3
        {4'd0,  4'd5,  5'd7,  1'b1, 3'd4},  // R5 slot 7 outside
        {4'd0,  4'd4,  5'd7,  1'b1, 3'd1},  // R5
        {4'd6,  4'd10, 5'd3,  1'b1, 3'd0},  // R4 wrapped window
        {4'd6,  4'd10, 5'd7,  1'b1, 3'd1},  // R4 youngest across wrap
        {4'd6,  4'd10, 5'd9,  1'b0, 3'd0},  // R5 match only outside
        {4'd3,  4'd3,  5'd9,  1'b0, 3'd0},  // R6 empty
        {4'd3,  4'd11, 5'd3,  1'b1, 3'd2},  // R4 full, wrap bits differ
        {4'd5,  4'd6,  5'd7,  1'b0, 3'd0},  // R5 one live slot
        {4'd5,  4'd6,  5'd3,  1'b1, 3'd5},  // R2
        {4'd12, 4'd15, 5'd7,  1'b1, 3'd4},  // R5 tail slot excluded
        {4'd9,  4'd1,  5'd9,  1'b1, 3'd3}   // R4 full, wrapped pointers
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            ent_dst[i*REG_W +: REG_W]   = DSTS[i];
            ent_data[i*DATA_W +: DATA_W] = 16'h0100 + 16'(i);
            ent_done[i]                 = i[0];
        end
        rst_n = 1'b0; req_valid = 1'b0; req_reg = '0;
        head_ptr = '0; tail_ptr = '0; arf_rdata = 16'hdead;
        repeat (3) @(negedge clk);
        // R9 outputs during reset
        check("R9 valid", 32'(rsp_valid), 0);
        check("R9 hit",   32'(rsp_hit),   0);
        check("R9 data",  32'(rsp_data),  0);
        check("R9 ready", 32'(rsp_ready), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 idle after reset", 32'({rsp_valid, rsp_hit, rsp_idx, rsp_data}), 0);

        for (int v = 0; v < NVEC; v++) begin
            logic [16:0] e;
            logic [DATA_W-1:0] exp_data;
            logic exp_ready;
            e = VECS[v];
            head_ptr  = e[16:13];
            tail_ptr  = e[12:9];
            req_reg   = e[8:4];
            arf_rdata = 16'ha000 + 16'(v);
            req_valid = 1'b1;
            @(negedge clk);
            exp_data  = e[3] ? 16'h0100 + 16'(e[2:0]) : 16'ha000 + 16'(v);
            exp_ready = e[3] ? e[0] : 1'b1;
            check("R1 valid",         32'(rsp_valid), 1);
            check("R2/R3 hit",        32'(rsp_hit),   32'(e[3]));
            check("R3/R4/R5 idx",     32'(rsp_idx),   32'(e[2:0]));
            check("R7/R8 data",       32'(rsp_data),  32'(exp_data));
            check("R7/R8 ready",      32'(rsp_ready), 32'(exp_ready));
        end

        // R10 idle cycle holds the last response (vector 12: hit slot 3)
        req_valid = 1'b0;
        arf_rdata = 16'h5555;
        req_reg   = 5'd3;
        @(negedge clk);
        check("R10 valid low", 32'(rsp_valid), 0);
        check("R10 hold hit",  32'(rsp_hit),   1);
        check("R10 hold idx",  32'(rsp_idx),   3);
        check("R10 hold data", 32'(rsp_data),  32'h0103);

        // R8 done bit sampled at request time
        ent_done[3] = 1'b0;
        head_ptr = 4'd3; tail_ptr = 4'd4; req_reg = 5'd9; req_valid = 1'b1;
        @(negedge clk);
        check("R8 ready follows done", 32'(rsp_ready), 0);
        check("R8 hit",                32'(rsp_hit),   1);

        // R6 empty with equal pointers after wrap
        head_ptr = 4'd13; tail_ptr = 4'd13; req_reg = 5'd7; arf_rdata = 16'h7777;
        @(negedge clk);
        check("R6 empty miss", 32'(rsp_hit),  0);
        check("R7 arf data",   32'(rsp_data), 32'h7777);
        check("R7 idx zero",   32'(rsp_idx),  0);
        req_valid = 1'b0;
        @(negedge clk);

        finished = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule